// File: doc/BRIEF.md
# Byte-Masked Read Output Stage for a Synchronous DRAM

This block forms the 16-bit read data bus of a synchronous DRAM together with one output-enable bit per byte lane. A read command loads a start column and a burst length; a burst counter then walks the columns, one per clock, and fetches words from the storage array through a combinational array port. Each fetched word is delayed by the programmed CAS latency before it reaches the data output.

Two mask inputs, one per byte lane, switch that lane's output enable off. A mask passes through a fixed two-register pipeline, so it takes effect two clocks after it is sampled, whatever the CAS latency. Masking touches only the enables. The burst counter and the data pipeline keep running, so a beat that falls inside a mask window is dropped rather than held back. The pad tristate buffers live outside this block and are driven from the enable bits.

Top module: `sdram_rd_bytemask`

## Requirements
- R1: While reset is held, `dq_oe` is 2'b00, `dq_out` is zero and `arr_rd` is low.
- R2: A read command sampled at clock edge E produces beat k on `dq_out` in the cycle that follows edge E+CL+k, where CL is `cas_lat` (1, 2 or 3). A `cas_lat` of 0 is treated as 1.
- R3: `rd_blen` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. After the last beat the output returns to idle.
- R4: Within a burst of length BL the column advances by one per beat and wraps inside the BL-aligned block that holds the start column. The column bits above that block never change.
- R5: A lane's enable goes low in the cycle that follows the second clock edge after its mask input is first sampled high. The delay is the same for every CAS latency.
- R6: A lane stays disabled for as long as its mask is sampled high. It is enabled again two clock edges after the mask is first sampled low.
- R7: `mask_hi` controls only `dq_oe[1]` (data bits 15:8) and `mask_lo` controls only `dq_oe[0]` (bits 7:0).
- R8: Masking never stalls the burst. A beat that is masked is lost, and the beats after it keep their R2 timing.
- R9: In any cycle with no valid read beat, `dq_oe` is 2'b00 and `dq_out` is zero, whatever the mask inputs are.
- R10: A read command that arrives during a burst restarts the counter at the new column. Beats already fetched still leave the pipeline on their original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_cmd | input | 1 | Read command strobe |
| rd_col | input | 8 | Start column of the burst |
| rd_blen | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| cas_lat | input | 2 | CAS latency in clocks (1 to 3) |
| mask_hi | input | 1 | Output mask for the upper byte lane |
| mask_lo | input | 1 | Output mask for the lower byte lane |
| arr_rd | output | 1 | Array fetch strobe, high once per burst beat |
| arr_col | output | 8 | Column being fetched |
| arr_data | input | 16 | Word returned by the array for `arr_col` in the same cycle |
| dq_out | output | 16 | Read data toward the pads |
| dq_oe | output | 2 | Per-lane output enable: bit 1 for 15:8, bit 0 for 7:0 |

## Verification
The assertions take `cas_lat` to be stable while any beat is still in the pipeline, because the data tap is chosen combinationally from it. They also take the array to answer in the same cycle as `arr_col`. The check for an idle output assumes a latency of at most three clocks. The stimulus changes `cas_lat` only together with a read command issued after the previous burst has drained. The one exception is the interrupted-read sequence, where both commands use the same latency. The array model is a pure function of the column, and the mask inputs are free to toggle in any cycle, because the design must accept any mask pattern.

// File: rtl/rdmask_pkg.sv
`timescale 1ns/1ps
package rdmask_pkg;

    typedef enum logic [1:0] {
        BLEN_1 = 2'd0,
        BLEN_2 = 2'd1,
        BLEN_4 = 2'd2,
        BLEN_8 = 2'd3
    } blen_e;

    localparam int BEAT_CNT_W = 4;

    // Number of beats selected by a burst length code.
    function automatic logic [BEAT_CNT_W-1:0] blen_beats(input blen_e b);
        return BEAT_CNT_W'(1) << b;
    endfunction

endpackage

// File: rtl/rdm_burst_ctr.sv
`timescale 1ns/1ps
module rdm_burst_ctr
    import rdmask_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  blen_e            blen_i,
    output logic             rd_o,
    output logic [COL_W-1:0] col_o
);

    localparam int BLK_LSB = 3;

    typedef struct packed {
        logic                  busy;
        logic [COL_W-1:0]      col;
        logic [COL_W-1:0]      wrap;
        logic [BEAT_CNT_W-1:0] left;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (cmd_i) begin
            ctr_d.busy = 1'b1;
            ctr_d.col  = col_i;
            ctr_d.wrap = COL_W'(blen_beats(blen_i) - 1'b1);
            ctr_d.left = blen_beats(blen_i) - 1'b1;
        end else if (ctr_q.busy) begin
            if (ctr_q.left == '0) begin
                ctr_d.busy = 1'b0;
            end else begin
                ctr_d.col  = (ctr_q.col & ~ctr_q.wrap) |
                             ((ctr_q.col + COL_W'(1)) & ctr_q.wrap);
                ctr_d.left = ctr_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign rd_o  = ctr_q.busy;
    assign col_o = ctr_q.col;

    // R3 R10
    no_rd_without_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_o) |-> $past(cmd_i));

    // R4
    col_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && $past(rd_o) && !$past(cmd_i)) |->
        (col_o[COL_W-1:BLK_LSB] == $past(col_o[COL_W-1:BLK_LSB])));

endmodule

// File: rtl/rdm_cas_pipe.sv
`timescale 1ns/1ps
module rdm_cas_pipe #(
    parameter int W      = 16,
    parameter int MAX_CL = 3,
    parameter int CL_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [W-1:0]    in_data,
    input  logic [CL_W-1:0] cl_i,
    output logic            out_valid,
    output logic [W-1:0]    out_data
);

    typedef struct packed {
        logic [MAX_CL-1:0]        v;
        logic [MAX_CL-1:0][W-1:0] d;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    int    tap;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.v[0] = in_valid;
        pipe_d.d[0] = in_data;
        for (int s = 1; s < MAX_CL; s++) begin
            pipe_d.v[s] = pipe_q.v[s-1];
            pipe_d.d[s] = pipe_q.d[s-1];
        end
    end

    always_comb begin
        if (cl_i == '0)                 tap = 0;
        else if (int'(cl_i) > MAX_CL)   tap = MAX_CL - 1;
        else                            tap = int'(cl_i) - 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.v[tap];
    assign out_data  = pipe_q.v[tap] ? pipe_q.d[tap] : '0;

    // R2
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(in_valid) || $past(|pipe_q.v)));

endmodule

// File: rtl/rdm_mask_pipe.sv
`timescale 1ns/1ps
module rdm_mask_pipe #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_i,
    output logic [LANES-1:0] en_o
);

    typedef struct packed {
        logic [LANES-1:0] s1;
        logic [LANES-1:0] s2;
        logic [1:0]       warm;
    } mpipe_t;

    mpipe_t mp_d, mp_q;

    always_comb begin
        mp_d = mp_q;
        for (int l = 0; l < LANES; l++) begin
            mp_d.s1[l] = mask_i[l];
            mp_d.s2[l] = mp_q.s1[l];
        end
        if (mp_q.warm != 2'd2) mp_d.warm = mp_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mp_q <= '0;
        else        mp_q <= mp_d;
    end

    assign en_o = ~mp_q.s2;

    // R5 R6 R7
    lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_q.warm == 2'd2) |-> (en_o == ~$past(mask_i, 2)));

endmodule

// File: rtl/sdram_rd_bytemask.sv
`timescale 1ns/1ps
module sdram_rd_bytemask
    import rdmask_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1),
    localparam int LANES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [1:0]        rd_blen,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic              mask_hi,
    input  logic              mask_lo,
    output logic              arr_rd,
    output logic [COL_W-1:0]  arr_col,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe
);

    logic              beat_valid;
    logic [DATA_W-1:0] beat_data;
    logic [LANES-1:0]  lane_en;

    rdm_burst_ctr #(.COL_W(COL_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (rd_cmd),
        .col_i  (rd_col),
        .blen_i (blen_e'(rd_blen)),
        .rd_o   (arr_rd),
        .col_o  (arr_col)
    );

    rdm_cas_pipe #(.W(DATA_W), .MAX_CL(MAX_CL), .CL_W(CL_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (arr_rd),
        .in_data   (arr_data),
        .cl_i      (cas_lat),
        .out_valid (beat_valid),
        .out_data  (beat_data)
    );

    rdm_mask_pipe #(.LANES(LANES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i ({mask_hi, mask_lo}),
        .en_o   (lane_en)
    );

    assign dq_out = beat_data;
    assign dq_oe  = {LANES{beat_valid}} & lane_en;

    // R9
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_rd && !$past(arr_rd) && !$past(arr_rd, 2) && !$past(arr_rd, 3))
        |-> (dq_oe == '0 && dq_out == '0));

endmodule

// File: tb/sdram_rd_bytemask_tb.sv
`timescale 1ns/1ps
module sdram_rd_bytemask_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_cmd;
    logic [7:0]  rd_col;
    logic [1:0]  rd_blen;
    logic [1:0]  cas_lat;
    logic        mask_hi, mask_lo;
    logic        arr_rd;
    logic [7:0]  arr_col;
    logic [15:0] arr_data;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit run_mon = 1'b0;
    bit done    = 1'b0;

    typedef struct {
        int          cyc;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [1:0] mhist [0:4095];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] arr_word(input logic [7:0] c);
        return {c ^ 8'h5A, ~c};
    endfunction

    assign arr_data = arr_word(arr_col);

    sdram_rd_bytemask u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cmd   (rd_cmd),
        .rd_col   (rd_col),
        .rd_blen  (rd_blen),
        .cas_lat  (cas_lat),
        .mask_hi  (mask_hi),
        .mask_lo  (mask_lo),
        .arr_rd   (arr_rd),
        .arr_col  (arr_col),
        .arr_data (arr_data),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s cyc=%0d actual=%h expected=%h", tag, what, cyc, act, exp);
        end
    endtask

    // Scoreboard monitor: samples at the falling edge
    exp_t       cur;
    logic [1:0] exp_oe;
    always @(negedge clk) begin
        if (run_mon) begin
            mhist[cyc] = {mask_hi, mask_lo};
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                cur    = exp_q.pop_front();
                exp_oe = ~mhist[cyc-2];
                chk(dq_out == cur.data, cur.tag, "data", dq_out, cur.data);
                chk(dq_oe == exp_oe, cur.tag, "oe", {14'd0, dq_oe}, {14'd0, exp_oe});
            end else begin
                chk(dq_oe == 2'b00, "R9", "idle oe", {14'd0, dq_oe}, 16'd0);
                chk(dq_out == 16'd0, "R9", "idle data", dq_out, 16'd0);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: issues one read and pushes the expected beats
    task automatic rd(input logic [7:0] col, input logic [1:0] bl, input int cl,
                      input int keep, input string tag);
        int          nb;
        logic [7:0]  m;
        logic [7:0]  ck;
        exp_t        e;
        nb = 1 << bl;
        if (keep < nb) nb = keep;
        m  = 8'((1 << bl) - 1);
        cas_lat = 2'(cl);
        rd_cmd  = 1'b1;
        rd_col  = col;
        rd_blen = bl;
        for (int k = 0; k < nb; k++) begin
            ck     = (col & ~m) | ((col + 8'(k)) & m);
            e.cyc  = cyc + 1 + cl + k;
            e.data = arr_word(ck);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        @(posedge clk);
        #1;
        rd_cmd = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mhist[i] = 2'b00;
        rst_n = 1'b0; rd_cmd = 1'b0; rd_col = '0; rd_blen = '0;
        cas_lat = 2'd2; mask_hi = 1'b0; mask_lo = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(dq_oe == 2'b00, "R1", "reset oe", {14'd0, dq_oe}, 16'd0);
        chk(dq_out == 16'd0, "R1", "reset data", dq_out, 16'd0);
        chk(arr_rd == 1'b0, "R1", "reset arr_rd", {15'd0, arr_rd}, 16'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_mon = 1'b1;
        idle(2);

        rd(8'h10, 2'd2, 2, 8, "R2");  idle(12);
        rd(8'h2D, 2'd3, 1, 8, "R4");  idle(12);
        rd(8'h07, 2'd0, 3, 8, "R3");  idle(8);
        rd(8'h0B, 2'd1, 3, 8, "R3");  idle(8);
        rd(8'h3E, 2'd3, 3, 8, "R2");  idle(12);

        // R8: upper lane masked mid-burst, beats lost but not delayed
        rd(8'h40, 2'd3, 3, 8, "R8");  idle(1);
        mask_hi = 1'b1; idle(3); mask_hi = 1'b0; idle(12);

        // R5: same two-clock mask latency at a different CAS latency
        rd(8'h50, 2'd3, 2, 8, "R5");  idle(1);
        mask_hi = 1'b1; idle(1); mask_hi = 1'b0; idle(12);

        // R7: lower lane only
        rd(8'h60, 2'd3, 1, 8, "R7");  idle(2);
        mask_lo = 1'b1; idle(2); mask_lo = 1'b0; idle(12);

        // R6: long mask hold, then release
        rd(8'h70, 2'd3, 2, 8, "R6");
        mask_hi = 1'b1; mask_lo = 1'b1; idle(5);
        mask_lo = 1'b0; idle(2); mask_hi = 1'b0; idle(12);

        // R9: masks toggling while idle
        for (int i = 0; i < 6; i++) begin
            mask_hi = ~mask_hi; idle(1);
            mask_lo = ~mask_hi; idle(1);
        end
        mask_hi = 1'b0; mask_lo = 1'b0; idle(4);

        // R10: second command three cycles into an 8-beat burst
        rd(8'h80, 2'd3, 2, 3, "R10"); idle(2);
        rd(8'h84, 2'd2, 2, 4, "R10"); idle(12);

        // R3: every expected beat has appeared
        chk(exp_q.size() == 0, "R3", "beats left", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule